// File: doc/BRIEF.md
# SDRAM Single-Write Command Sequencer

This block sits on the controller side of a synchronous DRAM and carries out one isolated write. It takes a request made of a bank, a row, a column, one data word and a byte mask. It then drives the registered command bus through this sequence:

- open the row;
- wait out the row-to-column delay;
- issue a single-beat write with auto-precharge disabled;
- wait for both write recovery and the minimum row-active time;
- close every bank with an explicit precharge;
- wait until a new row activation would be legal.

Every minimum interval is given in picoseconds. It is turned into a cycle count at elaboration time from the clock period parameter. The sequencer accepts one request at a time through a ready/valid pair. It signals the end of the row cycle with a one-cycle `done` pulse.

A user presents a request while `req_ready` is high. The user may then leave `req_valid` and the payload in any state until `done`. The next request is accepted no earlier than the cycle in which `done` is high.

Top module: `sdram_single_write`

## Requirements
- R1: In reset and in the first cycle after it, the command bus carries the idle code 0111, `sd_dq_oe` is 0, all `sd_dqm` bits are 1, `done` is 0, `req_ready` is 1 and `sd_cke` is 1. `sd_cke` stays 1 in every cycle.
- R2: A request is taken at a rising edge where `req_valid` and `req_ready` are both 1. In the next cycle the bus carries the row-open code 0011, `sd_ba` equals the request bank, and `sd_addr` equals the request row, zero-extended from bit 0.
- R3: The write code 0100 appears exactly N_RCD cycles after the row-open cycle, where each N_x = ceil(T_x_PS / CLK_PERIOD_PS), with a minimum of 1. In that cycle `sd_ba` is the captured bank, `sd_addr[COL_W-1:0]` is the captured column, and all other address bits, A10 included, are 0.
- R4: `sd_dq_oe` is 1 only in the write cycle. In that cycle `sd_dq_out` is the captured data word and `sd_dqm` is the captured mask, where bit i set to 1 suppresses byte i (`sd_dq_out[8i+7:8i]`). In every other cycle `sd_dqm` is all ones.
- R5: The precharge code 0010 appears at cycle max(write + N_WR, open + N_RAS), with `sd_addr[10]` = 1 to close all banks.
- R6: `done` is a one-cycle pulse at cycle max(precharge + N_RP, open + N_RC). `req_ready` returns to 1 in that same cycle.
- R7: Each accepted request produces exactly one row-open, one write and one precharge. Every other cycle carries the idle code 0111, and no other code ever appears.
- R8: While a request is in progress `req_ready` is 0. A held `req_valid` and changes to the request payload during that time have no effect on the bus.
- R9: The row stays open for no more than floor(T_RAS_MAX_PS / CLK_PERIOD_PS) cycles. A configuration whose precharge point would exceed this is rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_bank | input | BANK_W | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | Target column |
| req_data | input | DATA_W | Data word to write |
| req_mask | input | MASK_W | Byte mask, 1 = byte not written |
| done | output | 1 | Row cycle complete, next row-open legal |
| sd_cke | output | 1 | Clock enable, held high |
| sd_cmd | output | 4 | {CS#, RAS#, CAS#, WE#} command code |
| sd_ba | output | BANK_W | Bank address |
| sd_addr | output | ADDR_W | Multiplexed row/column address |
| sd_dq_out | output | DATA_W | Write data |
| sd_dq_oe | output | 1 | Data output enable |
| sd_dqm | output | MASK_W | Data mask |

## Verification
The hardest case to reach is a change of request payload while a write is already under way. Nothing at the ports reveals which values the sequencer captured. The stimulus therefore keeps `req_valid` high and scrambles the bank, row, column, data and mask on every cycle between acceptance and `done`. The bench then checks that the write beat and the bank still carry the first request's values, and that no second row-open appears before `done`. The bench sweeps every bank against every one of the sixteen mask patterns, with the column at both extremes and in between, and alternates held and dropped requests.

// File: rtl/sdwseq_pkg.sv
package sdwseq_pkg;

   // {CS#, RAS#, CAS#, WE#}
   typedef enum logic [3:0] {
      CMD_ACT   = 4'b0011,
      CMD_WRITE = 4'b0100,
      CMD_PRE   = 4'b0010,
      CMD_NOP   = 4'b0111
   } sd_cmd_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_ROW_OPEN,
      ST_RECOVER,
      ST_CLOSING
   } seq_state_e;

   localparam int unsigned NUM_GAPS = 5;
   localparam int unsigned GAP_RCD  = 0;   // open  -> write
   localparam int unsigned GAP_RAS  = 1;   // open  -> precharge
   localparam int unsigned GAP_RC   = 2;   // open  -> open
   localparam int unsigned GAP_WR   = 3;   // beat  -> precharge
   localparam int unsigned GAP_RP   = 4;   // close -> open

   localparam int unsigned AP_BIT = 10;    // auto/all-bank precharge address bit

   function automatic int unsigned ps_to_cycles(input int unsigned ps, input int unsigned clk_ps);
      int unsigned c;
      c = (ps + clk_ps - 1) / clk_ps;
      return (c == 0) ? 1 : c;
   endfunction

   function automatic int unsigned umax(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sdwseq_gap_timer.sv
module sdwseq_gap_timer #(
   parameter int unsigned LIMIT = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic due
);
   if (LIMIT < 1) begin : g_bad_limit
      $error("sdwseq_gap_timer: LIMIT must be at least 1");
   end

   if (LIMIT == 1) begin : g_immediate
      // next edge is already far enough away
      assign due = 1'b1;
   end else begin : g_counted
      localparam int unsigned CNT_W = $clog2(LIMIT);
      localparam logic [CNT_W-1:0] SAT = CNT_W'(LIMIT - 1);

      logic [CNT_W-1:0] cnt;

      always_ff @(posedge clk) begin
         if (!rst_n)          cnt <= SAT;
         else if (start)      cnt <= '0;
         else if (cnt != SAT) cnt <= cnt + 1'b1;
      end

      // asserted in the cycle before the one at distance LIMIT from the event
      assign due = (cnt == SAT);

      assert_start_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
         start |=> !due);
   end
endmodule

// File: rtl/sdwseq_ctrl.sv
module sdwseq_ctrl
   import sdwseq_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic [NUM_GAPS-1:0] gap_due,
   output logic                req_ready,
   output logic                issue_act,
   output logic                issue_wr,
   output logic                issue_pre,
   output logic                done
);
   seq_state_e state, state_nx;
   logic       finish;

   always_comb begin
      issue_act = 1'b0;
      issue_wr  = 1'b0;
      issue_pre = 1'b0;
      finish    = 1'b0;
      state_nx  = state;
      unique case (state)
         ST_IDLE: if (req_valid) begin
            issue_act = 1'b1;
            state_nx  = ST_ROW_OPEN;
         end
         ST_ROW_OPEN: if (gap_due[GAP_RCD]) begin
            issue_wr = 1'b1;
            state_nx = ST_RECOVER;
         end
         ST_RECOVER: if (gap_due[GAP_WR] && gap_due[GAP_RAS]) begin
            issue_pre = 1'b1;
            state_nx  = ST_CLOSING;
         end
         ST_CLOSING: if (gap_due[GAP_RP] && gap_due[GAP_RC]) begin
            finish   = 1'b1;
            state_nx = ST_IDLE;
         end
         default: state_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         done  <= 1'b0;
      end else begin
         state <= state_nx;
         done  <= finish;
      end
   end

   assign req_ready = (state == ST_IDLE);

   assert_accept_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_ready && req_valid) |=> !req_ready);
   assert_idle_wait_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_ready && !req_valid) |=> (req_ready && !done));
   assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_done_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> req_ready);
endmodule

// File: rtl/sdwseq_bus.sv
module sdwseq_bus
   import sdwseq_pkg::*;
#(
   parameter int unsigned BANK_W = 2,
   parameter int unsigned ROW_W  = 12,
   parameter int unsigned COL_W  = 8,
   parameter int unsigned ADDR_W = 12,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned MASK_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue_act,
   input  logic              issue_wr,
   input  logic              issue_pre,
   input  logic [BANK_W-1:0] req_bank,
   input  logic [ROW_W-1:0]  req_row,
   input  logic [COL_W-1:0]  req_col,
   input  logic [DATA_W-1:0] req_data,
   input  logic [MASK_W-1:0] req_mask,
   output logic [3:0]        sd_cmd,
   output logic [BANK_W-1:0] sd_ba,
   output logic [ADDR_W-1:0] sd_addr,
   output logic [DATA_W-1:0] sd_dq_out,
   output logic              sd_dq_oe,
   output logic [MASK_W-1:0] sd_dqm
);
   logic [BANK_W-1:0] held_bank;
   logic [COL_W-1:0]  held_col;
   logic [DATA_W-1:0] held_data;
   logic [MASK_W-1:0] held_mask;
   logic [ADDR_W-1:0] row_addr, col_addr;
   localparam logic [ADDR_W-1:0] CLOSE_ALL = ADDR_W'(1) << AP_BIT;

   // row placement: full width or zero-extended
   if (ROW_W == ADDR_W) begin : g_row_full
      assign row_addr = req_row;
   end else begin : g_row_ext
      assign row_addr = {{(ADDR_W-ROW_W){1'b0}}, req_row};
   end

   // column sits below the precharge bit, so A10 and up stay low
   assign col_addr = {{(ADDR_W-COL_W){1'b0}}, held_col};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held_bank <= '0;
         held_col  <= '0;
         held_data <= '0;
         held_mask <= '1;
      end else if (issue_act) begin
         held_bank <= req_bank;
         held_col  <= req_col;
         held_data <= req_data;
         held_mask <= req_mask;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sd_cmd    <= CMD_NOP;
         sd_ba     <= '0;
         sd_addr   <= '0;
         sd_dq_out <= '0;
         sd_dq_oe  <= 1'b0;
         sd_dqm    <= '1;
      end else begin
         sd_cmd    <= CMD_NOP;
         sd_dq_out <= '0;
         sd_dq_oe  <= 1'b0;
         sd_dqm    <= '1;
         if (issue_act) begin
            sd_cmd  <= CMD_ACT;
            sd_ba   <= req_bank;
            sd_addr <= row_addr;
         end else if (issue_wr) begin
            sd_cmd    <= CMD_WRITE;
            sd_ba     <= held_bank;
            sd_addr   <= col_addr;
            sd_dq_out <= held_data;
            sd_dq_oe  <= 1'b1;
            sd_dqm    <= held_mask;
         end else if (issue_pre) begin
            sd_cmd  <= CMD_PRE;
            sd_ba   <= held_bank;
            sd_addr <= CLOSE_ALL;
         end
      end
   end

   assert_single_beat_R4: assert property (@(posedge clk) disable iff (!rst_n)
      sd_dq_oe |=> !sd_dq_oe);
   assert_beat_follows_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (sd_cmd == CMD_ACT) |=> !sd_dq_oe || (sd_cmd == CMD_WRITE));
endmodule

// File: rtl/sdram_single_write.sv
module sdram_single_write
   import sdwseq_pkg::*;
#(
   parameter int unsigned BANK_W        = 2,
   parameter int unsigned ROW_W         = 12,
   parameter int unsigned COL_W         = 8,
   parameter int unsigned ADDR_W        = 12,
   parameter int unsigned DATA_W        = 32,
   parameter int unsigned MASK_W        = DATA_W / 8,
   parameter int unsigned CLK_PERIOD_PS = 7500,
   parameter int unsigned T_RCD_PS      = 18000,
   parameter int unsigned T_RAS_PS      = 42000,
   parameter int unsigned T_RAS_MAX_PS  = 120_000_000,
   parameter int unsigned T_WR_PS       = 12000,
   parameter int unsigned T_RP_PS       = 18000,
   parameter int unsigned T_RC_PS       = 60000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [BANK_W-1:0] req_bank,
   input  logic [ROW_W-1:0]  req_row,
   input  logic [COL_W-1:0]  req_col,
   input  logic [DATA_W-1:0] req_data,
   input  logic [MASK_W-1:0] req_mask,
   output logic              done,
   output logic              sd_cke,
   output logic [3:0]        sd_cmd,
   output logic [BANK_W-1:0] sd_ba,
   output logic [ADDR_W-1:0] sd_addr,
   output logic [DATA_W-1:0] sd_dq_out,
   output logic              sd_dq_oe,
   output logic [MASK_W-1:0] sd_dqm
);
   localparam int unsigned N_RCD     = ps_to_cycles(T_RCD_PS, CLK_PERIOD_PS);
   localparam int unsigned N_RAS     = ps_to_cycles(T_RAS_PS, CLK_PERIOD_PS);
   localparam int unsigned N_RC      = ps_to_cycles(T_RC_PS,  CLK_PERIOD_PS);
   localparam int unsigned N_WR      = ps_to_cycles(T_WR_PS,  CLK_PERIOD_PS);
   localparam int unsigned N_RP      = ps_to_cycles(T_RP_PS,  CLK_PERIOD_PS);
   localparam int unsigned N_RAS_MAX = T_RAS_MAX_PS / CLK_PERIOD_PS;
   localparam int unsigned N_PRE_AT  = umax(N_RCD + N_WR, N_RAS);
   localparam int unsigned GAP_LIM [NUM_GAPS] = '{N_RCD, N_RAS, N_RC, N_WR, N_RP};

   // ---- elaboration checks ----
   if (CLK_PERIOD_PS == 0) begin : g_bad_clk
      $error("clock period must be non-zero");
   end
   if (ADDR_W <= AP_BIT) begin : g_bad_addr
      $error("address bus must include the precharge bit");
   end
   if (ROW_W > ADDR_W) begin : g_bad_row
      $error("row wider than address bus");
   end
   if (COL_W > AP_BIT) begin : g_bad_col
      $error("column must fit below the precharge bit");
   end
   if (DATA_W % 8 != 0 || MASK_W != DATA_W / 8) begin : g_bad_mask
      $error("mask must carry one bit per data byte");
   end
   if (N_PRE_AT > N_RAS_MAX) begin : g_bad_ras_max_R9
      $error("precharge point exceeds the maximum row-active time");
   end

   logic issue_act, issue_wr, issue_pre;
   logic [NUM_GAPS-1:0] gap_start, gap_due;

   assign gap_start[GAP_RCD] = issue_act;
   assign gap_start[GAP_RAS] = issue_act;
   assign gap_start[GAP_RC]  = issue_act;
   assign gap_start[GAP_WR]  = issue_wr;
   assign gap_start[GAP_RP]  = issue_pre;

   for (genvar g = 0; g < NUM_GAPS; g++) begin : g_gap
      sdwseq_gap_timer #(.LIMIT(GAP_LIM[g])) u_timer (
         .clk   (clk),
         .rst_n (rst_n),
         .start (gap_start[g]),
         .due   (gap_due[g])
      );
   end

   sdwseq_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .gap_due   (gap_due),
      .req_ready (req_ready),
      .issue_act (issue_act),
      .issue_wr  (issue_wr),
      .issue_pre (issue_pre),
      .done      (done)
   );

   sdwseq_bus #(
      .BANK_W (BANK_W),
      .ROW_W  (ROW_W),
      .COL_W  (COL_W),
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .MASK_W (MASK_W)
   ) u_bus (
      .clk       (clk),
      .rst_n     (rst_n),
      .issue_act (issue_act),
      .issue_wr  (issue_wr),
      .issue_pre (issue_pre),
      .req_bank  (req_bank),
      .req_row   (req_row),
      .req_col   (req_col),
      .req_data  (req_data),
      .req_mask  (req_mask),
      .sd_cmd    (sd_cmd),
      .sd_ba     (sd_ba),
      .sd_addr   (sd_addr),
      .sd_dq_out (sd_dq_out),
      .sd_dq_oe  (sd_dq_oe),
      .sd_dqm    (sd_dqm)
   );

   assign sd_cke = 1'b1;

   // ---- bus-level interval watch, independent of the gap timers ----
   localparam int unsigned CHK_W = $clog2(N_RAS_MAX + N_RC + 8);
   localparam logic [CHK_W-1:0] CHK_SAT = '1;

   logic [CHK_W-1:0] since_act, since_wr, since_pre;
   logic             row_open;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         since_act <= '0;
         since_wr  <= '0;
         since_pre <= '0;
         row_open  <= 1'b0;
      end else begin
         since_act <= (sd_cmd == CMD_ACT)   ? CHK_W'(1) : (since_act == CHK_SAT) ? since_act : since_act + 1'b1;
         since_wr  <= (sd_cmd == CMD_WRITE) ? CHK_W'(1) : (since_wr  == CHK_SAT) ? since_wr  : since_wr  + 1'b1;
         since_pre <= (sd_cmd == CMD_PRE)   ? CHK_W'(1) : (since_pre == CHK_SAT) ? since_pre : since_pre + 1'b1;
         if (sd_cmd == CMD_ACT)      row_open <= 1'b1;
         else if (sd_cmd == CMD_PRE) row_open <= 1'b0;
      end
   end

   assert_open_to_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (sd_cmd == CMD_WRITE) |-> (since_act == CHK_W'(N_RCD)));
   assert_close_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (sd_cmd == CMD_PRE) |-> (since_act >= CHK_W'(N_RAS) && since_wr >= CHK_W'(N_WR)));
   assert_close_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (sd_cmd == CMD_PRE) |-> sd_addr[AP_BIT]);
   assert_next_open_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (since_act >= CHK_W'(N_RC) && since_pre >= CHK_W'(N_RP)));
   assert_row_open_limit_R9: assert property (@(posedge clk) disable iff (!rst_n)
      row_open |-> (since_act <= CHK_W'(N_RAS_MAX)));
   assert_no_write_closed_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (sd_cmd == CMD_WRITE) |-> row_open);
endmodule

// File: tb/sdram_single_write_test.sv
`timescale 1ns/1ps
module sdram_single_write_test;
   localparam int CLK_PS = 10000;
   localparam int RCD_PS = 18000, RAS_PS = 42000, RASMX_PS = 120_000_000;
   localparam int WR_PS = 12000, RP_PS = 18000, RC_PS = 60000;

   function automatic int cyc(input int ps);
      int c;
      c = (ps + CLK_PS - 1) / CLK_PS;
      return (c < 1) ? 1 : c;
   endfunction
   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   localparam logic [3:0] C_ACT = 4'b0011, C_WR = 4'b0100, C_PRE = 4'b0010, C_NOP = 4'b0111;

   int n_rcd, n_ras, n_rc, n_wr, n_rp, n_rasmx;
   int vecs = 0, miss = 0;

   logic        clk = 1'b0, rst_n = 1'b0, req_valid = 1'b0;
   logic        req_ready, done, sd_cke, sd_dq_oe;
   logic [1:0]  req_bank = '0, sd_ba;
   logic [11:0] req_row = '0, sd_addr;
   logic [7:0]  req_col = '0;
   logic [31:0] req_data = '0, sd_dq_out;
   logic [3:0]  req_mask = '0, sd_dqm, sd_cmd;

   always #5 clk = ~clk;

   sdram_single_write #(
      .BANK_W(2), .ROW_W(12), .COL_W(8), .ADDR_W(12), .DATA_W(32), .MASK_W(4),
      .CLK_PERIOD_PS(CLK_PS), .T_RCD_PS(RCD_PS), .T_RAS_PS(RAS_PS),
      .T_RAS_MAX_PS(RASMX_PS), .T_WR_PS(WR_PS), .T_RP_PS(RP_PS), .T_RC_PS(RC_PS)
   ) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
      .req_data(req_data), .req_mask(req_mask), .done(done), .sd_cke(sd_cke),
      .sd_cmd(sd_cmd), .sd_ba(sd_ba), .sd_addr(sd_addr), .sd_dq_out(sd_dq_out),
      .sd_dq_oe(sd_dq_oe), .sd_dqm(sd_dqm)
   );

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      vecs++;
      if (!ok) begin
         miss++;
         $display("FAIL %s: got %0h expected %0h (t=%0t)", tag, act, exp, $time);
      end
   endtask

   task automatic run_write(input logic [1:0] ba, input logic [11:0] row, input logic [7:0] col,
                            input logic [31:0] data, input logic [3:0] mask, input bit hold);
      int act_k = -1, wr_k = -1, pre_k = -1, done_k = -1;
      int e_wr, e_pre, e_done;
      e_wr   = 1 + n_rcd;
      e_pre  = imax(e_wr + n_wr, 1 + n_ras);
      e_done = imax(e_pre + n_rp, 1 + n_rc);
      @(negedge clk);
      chk(req_ready == 1'b1, "R2 ready before request", req_ready, 1);
      req_valid = 1'b1; req_bank = ba; req_row = row; req_col = col;
      req_data = data; req_mask = mask;
      for (int k = 1; k <= e_done + 1; k++) begin
         @(negedge clk);
         case (sd_cmd)
            C_ACT: begin
               if (act_k < 0) act_k = k;
               else chk(1'b0, "R7 second row-open", k, act_k);
               chk(sd_ba == ba, "R2 open bank", sd_ba, ba);
               chk(sd_addr == row, "R2 open row", sd_addr, row);
            end
            C_WR: begin
               wr_k = k;
               chk(sd_ba == ba, "R3 write bank", sd_ba, ba);
               chk(sd_addr == {4'h0, col}, "R3 write column, A10 low", sd_addr, {4'h0, col});
               chk(sd_dq_out == data, "R4 write data", sd_dq_out, data);
               chk(sd_dqm == mask, "R4 write mask", sd_dqm, mask);
            end
            C_PRE: begin
               pre_k = k;
               chk(sd_addr[10] == 1'b1, "R5 close-all bit", sd_addr[10], 1);
            end
            C_NOP: ;
            default: chk(1'b0, "R7 illegal command code", sd_cmd, C_NOP);
         endcase
         chk(sd_dq_oe == (sd_cmd == C_WR), "R4 output enable", sd_dq_oe, sd_cmd == C_WR);
         if (sd_cmd != C_WR) chk(sd_dqm == 4'hF, "R4 idle mask", sd_dqm, 4'hF);
         chk(sd_cke == 1'b1, "R1 clock enable", sd_cke, 1);
         chk(req_ready == (k >= e_done), "R8 ready only when idle", req_ready, k >= e_done);
         if (done) begin
            if (done_k < 0) done_k = k;
            else chk(1'b0, "R6 done longer than one cycle", k, done_k);
         end
         if (hold && k < e_done) begin
            req_bank = req_bank + 2'd1; req_row = ~req_row; req_col = req_col + 8'd91;
            req_data = ~req_data ^ 32'(k); req_mask = ~req_mask;
         end else begin
            req_valid = 1'b0;
         end
      end
      chk(act_k == 1, "R2 open one cycle after acceptance", act_k, 1);
      chk(wr_k == e_wr, "R3 write cycle", wr_k, e_wr);
      chk(pre_k == e_pre, "R5 precharge cycle", pre_k, e_pre);
      chk(pre_k - act_k <= n_rasmx, "R9 row-open limit", pre_k - act_k, n_rasmx);
      chk(done_k == e_done, "R6 done cycle", done_k, e_done);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      miss++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
      $finish;
   end

   initial begin
      n_rcd = cyc(RCD_PS); n_ras = cyc(RAS_PS); n_rc = cyc(RC_PS);
      n_wr = cyc(WR_PS); n_rp = cyc(RP_PS); n_rasmx = RASMX_PS / CLK_PS;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(sd_cmd == C_NOP, "R1 idle code in reset", sd_cmd, C_NOP);
      chk(req_ready == 1'b1, "R1 ready in reset", req_ready, 1);
      rst_n = 1'b1;
      @(negedge clk);
      chk(sd_cmd == C_NOP, "R1 idle code after reset", sd_cmd, C_NOP);
      chk(sd_dq_oe == 1'b0, "R1 output enable", sd_dq_oe, 0);
      chk(sd_dqm == 4'hF, "R1 mask", sd_dqm, 4'hF);
      chk(done == 1'b0, "R1 done", done, 0);
      chk(req_ready == 1'b1, "R1 ready", req_ready, 1);
      chk(sd_cke == 1'b1, "R1 clock enable", sd_cke, 1);
      // payload moving without valid must leave the bus idle
      for (int i = 0; i < 6; i++) begin
         req_bank = 2'(i); req_row = 12'(i * 301); req_data = 32'(i * 7);
         @(negedge clk);
         chk(sd_cmd == C_NOP, "R2 no request without valid", sd_cmd, C_NOP);
      end
      for (int b = 0; b < 4; b++) begin
         for (int m = 0; m < 16; m++) begin
            logic [7:0] col;
            col = (m == 0) ? 8'h00 : (m == 15) ? 8'hFF : 8'((m * 37) & 8'hFF);
            run_write(2'(b), 12'(((b * 16 + m) * 97) & 12'hFFF) | ((m == 15) ? 12'hFFF : 12'h0),
                      col, 32'((b * 16 + m + 1) * 32'h01010101) ^ 32'hA5C30F96,
                      4'(m), m[0]);
         end
      end
      $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
      $finish;
   end
endmodule